// File: doc/BRIEF.md
# Edge-Interval Bit-Check Validator

This block decides whether a demodulated data stream looks like a real transmitter signal or like noise. After a start strobe it waits for the first transition on the data line. That transition only opens the measurement. From then on, it times each gap between successive transitions, in either direction, by counting ticks of a scaled timing enable. Each gap must land inside a programmable window. Enough in-window gaps in a row produce a one-cycle pass pulse, and the downstream logic can then route the data onward. Any gap that ends too early, or that runs up to the upper limit with no transition, produces a one-cycle fail pulse at once.

The number of gaps required comes from a 2-bit code that selects 0, 3, 6 or 9 bits. Every bit carries two transitions, so the block checks 0, 6, 12 or 18 gaps. The data input comes from another clock domain and passes through a synchronizer before its transitions are detected.

Top module: `edge_window_checker`

## Requirements
- R1: After reset, `pass_o`, `fail_o` and `busy_o` are all 0.
- R2: A `start` pulse makes `busy_o` 1 on the next cycle. While `busy_o` is 0, transitions on `data_in` produce no pulse on `pass_o` or `fail_o`.
- R3: The first transition after `start` is not judged and only begins timing. If `nbits_code` is 0 at start, that first transition produces a pass pulse.
- R4: A gap is measured as the number of `tick_en` cycles between two detected transitions. The counter returns to 0 at each transition, so the first tick afterwards reads 1. A transition that ends a gap shorter than `lim_lo` ticks produces a fail pulse.
- R5: If the count reaches `lim_hi` before the next transition, a fail pulse is issued on that tick, without waiting for a transition.
- R6: A gap of N ticks with `lim_lo` <= N <= `lim_hi`-1 is accepted, whether it ends on a rising or a falling transition.
- R7: `nbits_code` is captured at `start`. The code values 0, 1, 2 and 3 require 0, 6, 12 and 18 accepted gaps. The pass pulse follows the last required gap and never an earlier one.
- R8: `pass_o` and `fail_o` are single-cycle pulses that never occur together, and `busy_o` is 0 in the cycle a pulse is high.
- R9: A `start` while a check is running discards the progress so far and waits again for a first, unjudged transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Asynchronous demodulated data bit |
| tick_en | input | 1 | One-cycle timing enable at the scaled check rate |
| start | input | 1 | Begins a new check and captures `nbits_code` |
| lim_lo | input | 6 | Shortest accepted gap, in ticks |
| lim_hi | input | 6 | Count at which a gap is declared too long |
| nbits_code | input | 2 | Selects 0, 6, 12 or 18 required gaps |
| pass_o | output | 1 | Pulse: enough valid gaps seen |
| fail_o | output | 1 | Pulse: a gap fell outside the window |
| busy_o | output | 1 | A check is in progress |

## Verification
The hardest conditions to reach are the exact window edges: a gap of exactly `lim_lo` or `lim_hi`-1 ticks against one a single tick shorter or longer. Each tick comes from the bench. The tick and every data transition sit in fixed four-cycle slots, with the tick on the slot's first cycle and the synchronizer delay putting the detected transition two cycles later. A gap is therefore exactly the number of slots between two toggles. For the too-long case, the bench counts empty slots and checks that no fail occurs one slot before the limit and that it occurs on the limit slot.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

    localparam int LIM_W          = 6;
    localparam int CODE_W         = 2;
    localparam int EDGES_PER_BIT  = 2;
    localparam int BITS_PER_STEP  = 3;
    localparam int MAX_NEED       = ((1 << CODE_W) - 1) * BITS_PER_STEP * EDGES_PER_BIT;
    localparam int NEED_W         = $clog2(MAX_NEED + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_MEAS = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        IV_NONE  = 2'd0,
        IV_EARLY = 2'd1,
        IV_GOOD  = 2'd2,
        IV_LATE  = 2'd3
    } iv_result_e;

    typedef struct packed {
        logic pass;
        logic fail;
    } verdict_t;

    function automatic logic [NEED_W-1:0] need_intervals(input logic [CODE_W-1:0] code);
        logic [NEED_W+CODE_W-1:0] prod;
        prod = code * (BITS_PER_STEP * EDGES_PER_BIT);
        return prod[NEED_W-1:0];
    endfunction

endpackage

// File: rtl/ewc_edge_det.sv
module ewc_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[SYNC_STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[SYNC_STAGES-1];
    end

    assign edge_o = chain[SYNC_STAGES-1] ^ prev;
endmodule

// File: rtl/ewc_interval_ctr.sv
module ewc_interval_ctr
    import ewc_pkg::*;
#(
    parameter int CW = LIM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    input  logic          edge_i,
    input  logic [CW-1:0] lim_lo,
    input  logic [CW-1:0] lim_hi,
    output iv_result_e    result
);
    logic [CW-1:0] count;
    logic [CW:0]   nxt;

    assign nxt = {1'b0, count} + 1'b1;

    always_comb begin
        result = IV_NONE;
        if (run) begin
            if (edge_i)
                result = (count < lim_lo) ? IV_EARLY : IV_GOOD;
            else if (tick && (nxt >= {1'b0, lim_hi}))
                result = IV_LATE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear || edge_i)
            count <= '0;
        else if (run && tick && !(&count))
            count <= nxt[CW-1:0];
    end
endmodule

// File: rtl/ewc_seq_fsm.sv
module ewc_seq_fsm
    import ewc_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NW = NEED_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          edge_i,
    input  iv_result_e    result,
    input  logic [CW-1:0] code,
    output logic          run,
    output logic          clear,
    output verdict_t      verdict,
    output logic          busy
);
    seq_state_e    state_q;
    logic [NW-1:0] done_q;
    logic [NW-1:0] need_q;
    logic [NW:0]   done_inc;

    assign done_inc = {1'b0, done_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= '0;
            need_q  <= '0;
            verdict <= '0;
        end else begin
            verdict <= '0;
            if (start) begin
                state_q <= ST_ARM;
                done_q  <= '0;
                need_q  <= need_intervals(code);
            end else begin
                case (state_q)
                    ST_ARM: begin
                        if (edge_i) begin
                            if (need_q == '0) begin
                                verdict.pass <= 1'b1;
                                state_q      <= ST_IDLE;
                            end else begin
                                state_q <= ST_MEAS;
                            end
                        end
                    end
                    ST_MEAS: begin
                        case (result)
                            IV_EARLY, IV_LATE: begin
                                verdict.fail <= 1'b1;
                                state_q      <= ST_IDLE;
                            end
                            IV_GOOD: begin
                                if (done_inc == {1'b0, need_q}) begin
                                    verdict.pass <= 1'b1;
                                    state_q      <= ST_IDLE;
                                end else begin
                                    done_q <= done_inc[NW-1:0];
                                end
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign run   = (state_q == ST_MEAS);
    assign clear = start || (state_q != ST_MEAS);
endmodule

// File: rtl/edge_window_checker.sv
module edge_window_checker
    import ewc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_in,
    input  logic              tick_en,
    input  logic              start,
    input  logic [LIM_W-1:0]  lim_lo,
    input  logic [LIM_W-1:0]  lim_hi,
    input  logic [CODE_W-1:0] nbits_code,
    output logic              pass_o,
    output logic              fail_o,
    output logic              busy_o
);
    logic       edge_w;
    logic       run_w;
    logic       clear_w;
    iv_result_e result_w;
    verdict_t   verdict_w;

    ewc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .din    (data_in),
        .edge_o (edge_w)
    );

    ewc_interval_ctr #(.CW(LIM_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear_w),
        .run    (run_w),
        .tick   (tick_en),
        .edge_i (edge_w),
        .lim_lo (lim_lo),
        .lim_hi (lim_hi),
        .result (result_w)
    );

    ewc_seq_fsm #(.CW(CODE_W), .NW(NEED_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .edge_i  (edge_w),
        .result  (result_w),
        .code    (nbits_code),
        .run     (run_w),
        .clear   (clear_w),
        .verdict (verdict_w),
        .busy    (busy_o)
    );

    assign pass_o = verdict_w.pass;
    assign fail_o = verdict_w.fail;
endmodule

// File: rtl/ewc_props.sv
module ewc_props (
    input logic clk,
    input logic rst,
    input logic start,
    input logic pass_o,
    input logic fail_o,
    input logic busy_o
);
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o));

    p_pass_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        pass_o |=> !pass_o);

    p_fail_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> !fail_o);

    p_idle_on_verdict_r8: assert property (@(posedge clk) disable iff (rst)
        (pass_o || fail_o) |-> !busy_o);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_o);

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start) |=> (!pass_o && !fail_o));
endmodule

bind edge_window_checker ewc_props u_props (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .pass_o (pass_o),
    .fail_o (fail_o),
    .busy_o (busy_o)
);

// File: tb/tb_edge_window_checker.sv
module tb_edge_window_checker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_in = 1'b0;
    logic       tick_en = 1'b0;
    logic       start = 1'b0;
    logic [5:0] lim_lo = 6'd6;
    logic [5:0] lim_hi = 6'd12;
    logic [1:0] nbits_code = 2'd0;
    logic       pass_o, fail_o, busy_o;

    int n_checks = 0;
    int n_failed = 0;
    int n_pass = 0;
    int n_fail = 0;
    int n_bad_busy = 0;
    int n_wide = 0;
    bit last_p = 1'b0;
    bit last_f = 1'b0;

    always #5 clk = ~clk;

    edge_window_checker dut (
        .clk(clk), .rst(rst), .data_in(data_in), .tick_en(tick_en),
        .start(start), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .nbits_code(nbits_code), .pass_o(pass_o), .fail_o(fail_o),
        .busy_o(busy_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (pass_o) n_pass++;
            if (fail_o) n_fail++;
            if ((pass_o || fail_o) && busy_o) n_bad_busy++;
            if ((pass_o && last_p) || (fail_o && last_f)) n_wide++;
            last_p = pass_o;
            last_f = fail_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // One slot = 4 cycles, tick on the first; optional data toggle at slot start.
    task automatic slot(input bit tog);
        step();
        if (tog) data_in = ~data_in;
        tick_en = 1'b1;
        step();
        tick_en = 1'b0;
        step();
        step();
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n - 1; i++) slot(1'b0);
        slot(1'b1);
    endtask

    task automatic do_start(input logic [1:0] code);
        nbits_code = code;
        step();
        start = 1'b1;
        step();
        start = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    endtask

    task automatic t_reset();
        chk(pass_o == 0 && fail_o == 0 && busy_o == 0, "R1 reset outputs",
            {pass_o, fail_o, busy_o}, 0);
    endtask

    task automatic t_idle_ignored();
        int p0 = n_pass, f0 = n_fail;
        for (int i = 0; i < 4; i++) gap(3);
        chk(n_pass == p0 && n_fail == f0, "R2 idle edges ignored",
            n_pass + n_fail - p0 - f0, 0);
        chk(busy_o == 0, "R2 busy stays low", busy_o, 0);
    endtask

    task automatic t_code0();
        int p0 = n_pass;
        do_start(2'd0);
        slot(1'b0);
        chk(n_pass == p0, "R3 no pass before first edge", n_pass - p0, 0);
        slot(1'b1);
        chk(n_pass == p0 + 1, "R3 code 0 passes on first edge", n_pass - p0, 1);
        chk(busy_o == 0, "R8 busy low after pass", busy_o, 0);
    endtask

    task automatic t_code1_bounds();
        int p0 = n_pass, f0 = n_fail;
        do_start(2'd1);
        slot(1'b1);
        gap(6); gap(11); gap(6); gap(11); gap(8);
        chk(n_pass == p0 && busy_o == 1, "R7 no pass after 5 of 6", n_pass - p0, 0);
        gap(11);
        chk(n_pass == p0 + 1, "R6 R7 pass at lim_lo and lim_hi-1 gaps", n_pass - p0, 1);
        chk(n_fail == f0, "R6 no fail on in-window gaps", n_fail - f0, 0);
    endtask

    task automatic t_early();
        int f0 = n_fail, p0 = n_pass;
        do_start(2'd1);
        slot(1'b1);
        gap(8); gap(8);
        gap(5);
        chk(n_fail == f0 + 1, "R4 gap of lim_lo-1 fails", n_fail - f0, 1);
        chk(busy_o == 0 && n_pass == p0, "R4 idle after early fail", busy_o, 0);
        gap(8);
        chk(n_fail == f0 + 1 && n_pass == p0, "R2 edges after fail ignored",
            n_fail - f0, 1);
    endtask

    task automatic t_late();
        int f0 = n_fail;
        do_start(2'd1);
        slot(1'b1);
        gap(8);
        for (int i = 0; i < 11; i++) slot(1'b0);
        chk(n_fail == f0 && busy_o == 1, "R5 no fail at count lim_hi-1",
            n_fail - f0, 0);
        slot(1'b0);
        chk(n_fail == f0 + 1, "R5 fail when count reaches lim_hi", n_fail - f0, 1);
        chk(busy_o == 0, "R5 idle after late fail", busy_o, 0);
    endtask

    task automatic t_code(input logic [1:0] code, input int need);
        int p0 = n_pass;
        do_start(code);
        slot(1'b1);
        for (int i = 0; i < need - 1; i++) gap(7 + (i % 3));
        chk(n_pass == p0 && busy_o == 1, $sformatf("R7 code %0d no early pass", code),
            n_pass - p0, 0);
        gap(9);
        chk(n_pass == p0 + 1, $sformatf("R7 code %0d pass after %0d gaps", code, need),
            n_pass - p0, 1);
    endtask

    task automatic t_restart();
        int p0 = n_pass;
        do_start(2'd1);
        slot(1'b1);
        gap(8); gap(8); gap(8);
        do_start(2'd1);
        slot(1'b0);
        slot(1'b1);
        for (int i = 0; i < 5; i++) gap(8);
        chk(n_pass == p0, "R9 restart discards progress", n_pass - p0, 0);
        gap(8);
        chk(n_pass == p0 + 1, "R9 pass after full count post restart", n_pass - p0, 1);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_idle_ignored();
        t_code0();
        t_code1_bounds();
        t_early();
        t_late();
        t_code(2'd2, 12);
        t_code(2'd3, 18);
        t_restart();
        chk(n_wide == 0, "R8 pulses one cycle wide", n_wide, 0);
        chk(n_bad_busy == 0, "R8 busy low with pulse", n_bad_busy, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_failed);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_failed++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_failed);
        $finish;
    end
endmodule